// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator with Selectable Clear Modes

This block collects single-cycle event pulses from several groups of interrupt sources for one channel and drives a single active-low interrupt request. Each group has a sticky status register and a per-bit enable register at the source level. The block level has one enable bit per group, and a master enable sits in a channel control register. An event reaches the request output only when all three levels allow it.

A host reaches every register over a byte-wide bus with separate read and write strobes. A control bit selects how status is cleared. In one mode a read returns the status and empties the register. In the other mode reads leave the status untouched, and the host must write zero to clear it. A second control bit makes a status read drop the source enables of the bits that were set. This stops a fault that keeps firing from raising the request again and again.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, all registers read 0 and `int_n` is high.
- R2: The register map is: control at address 0, block enable at 1 (bit g enables group g), block status at 2, and for group g the source status at 4+2g and the source enable at 5+2g. In the control register, bit 0 is the master enable, bit 1 is enable auto-clear, and bit 2 is the clear mode (0 clears on read, 1 clears on a zero write). Bits 7..3 read as 0.
- R3: An event pulse on `evt[8g+i]` sets status bit i of group g, and the bit stays set until it is cleared. An event in the same cycle as a clear wins, so the bit is set afterwards.
- R4: `int_n` is low exactly when some status bit is set and that bit's source enable, its group's block enable and the master enable are all 1.
- R5: Block status bit g is the OR over group g of (status AND source enable). Writes to the block status address have no effect.
- R6: In clear-on-read mode, a status read returns the current contents and the register reads 0x00 afterwards. `int_n` goes high once the last register holding enabled active bits has been read.
- R7: In write-zero mode, a status read does not change the register. Writing 0x00 clears the register, and `int_n` stays low until that write.
- R8: In write-zero mode, writing any nonzero value to a status register leaves it unchanged.
- R9: With auto-clear set, a status read clears the source enable bits of every status bit that was set at the read. With auto-clear cleared, a status read leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; triggers read side effects |
| rd_data | output | DATA_W | Read data for `addr` (combinational) |
| evt | input | NUM_GRP*SRC_W | Event pulses, group g bit i at index SRC_W*g+i |
| int_n | output | 1 | Active-low interrupt request |

## Verification
A sweep covers every source bit of every group against all eight combinations of master, block and source enable. In that sweep `int_n` and the block status separate a correct three-level gate from one that ignores any single level. Fixed sequences cover the two clear modes. Reading twice tells clear-on-read from write-zero behaviour. Two active groups show that the request stays low until the last register is serviced. A nonzero write shows it is ignored. An event that meets a clearing read in the same cycle checks the priority rule. Auto-clear is tried on and off, and the bench checks that a repeated event stays masked after an auto-clearing read.

// File: rtl/irq_hier_pkg.sv
// Shared address map and control-field positions for the interrupt aggregator.
package irq_hier_pkg;
    localparam int CTRL_ADDR  = 0;
    localparam int BEN_ADDR   = 1;
    localparam int BSTAT_ADDR = 2;
    localparam int SRC_BASE   = 4;

    typedef struct packed {
        logic wc_mode;   // bit 2
        logic autoclr;   // bit 1
        logic master;    // bit 0
    } ctrl_t;
endpackage

// File: rtl/irq_ctrl_regs.sv
// Channel control register and block enable register.
// Assumes the decode strobes are one-hot and come from the top-level address decoder.
module irq_ctrl_regs #(
    parameter int NUM_GRP = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_ctrl,
    input  logic                        wr_ben,
    input  logic [2:0]                  ctrl_wdata,
    input  logic [NUM_GRP-1:0]          ben_wdata,
    output irq_hier_pkg::ctrl_t         ctrl,
    output logic [NUM_GRP-1:0]          blk_en
);
    // Hold the control fields and the block enables; both reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            blk_en <= '0;
        end else begin
            if (wr_ctrl) ctrl   <= ctrl_wdata;
            if (wr_ben)  blk_en <= ben_wdata;
        end
    end

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl == $past(ctrl_wdata)));
endmodule

// File: rtl/irq_src_grp.sv
// One source group: sticky status bits and per-bit enables.
// Status clears on read or on a zero write, depending on mode; events win over clears.
// With auto-clear set, a status read drops the enables of the bits that were set.
module irq_src_grp #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt,
    input  logic             wr_sts,
    input  logic             wr_en_reg,
    input  logic             rd_sts,
    input  logic             wc_mode,
    input  logic             autoclr,
    input  logic             wr_zero,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] sts,
    output logic [SRC_W-1:0] en,
    output logic             flag
);
    logic clr;

    // Pick the clear condition for the selected mode.
    always_comb clr = wc_mode ? (wr_sts && wr_zero) : rd_sts;

    // Sticky status: clear, then OR in new events so events are never lost.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (clr ? '0 : sts) | evt;
    end

    // Enables: host write first, otherwise auto-clear on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en <= '0;
        else if (wr_en_reg)          en <= wdata;
        else if (autoclr && rd_sts)  en <= en & ~sts;
    end

    // Group flag used as block status.
    always_comb flag = |(sts & en);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((sts & $past(sts)) == $past(sts)));
    // R3
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts & $past(evt)) == $past(evt)));
    // R6
    rur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wc_mode && rd_sts && !(|evt)) |=> (sts == '0));
    // R7
    wc_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_mode && rd_sts && !wr_sts && !(|evt)) |=> $stable(sts));
    // R8
    wc_nonzero_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_mode && wr_sts && !wr_zero && !(|evt)) |=> $stable(sts));
    // R9
    autoclr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (autoclr && rd_sts && !wr_en_reg) |=> ((en & $past(sts)) == '0));
endmodule

// File: rtl/irq_hier_ctrl.sv
// Top level: address decode, read-back mux, source groups and the request output.
// Assumes SRC_W and NUM_GRP do not exceed DATA_W, and that the map fits in ADDR_W.
module irq_hier_ctrl #(
    parameter int NUM_GRP = 2,
    parameter int SRC_W   = 8,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NUM_GRP*SRC_W-1:0]   evt,
    output logic                       int_n
);
    import irq_hier_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_BEN   = ADDR_W'(BEN_ADDR);
    localparam logic [ADDR_W-1:0] A_BSTAT = ADDR_W'(BSTAT_ADDR);

    ctrl_t              ctrl;
    logic [NUM_GRP-1:0] blk_en;
    logic [NUM_GRP-1:0] blk_stat;
    logic [NUM_GRP-1:0] hit_sts;
    logic [NUM_GRP-1:0] hit_en;
    logic [SRC_W-1:0]   sts_a [NUM_GRP];
    logic [SRC_W-1:0]   en_a  [NUM_GRP];
    logic               wr_zero;

    // Flag an all-zero write value for the write-zero clear mode.
    always_comb wr_zero = (wr_data == '0);

    irq_ctrl_regs #(.NUM_GRP(NUM_GRP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_en && (addr == A_CTRL)),
        .wr_ben     (wr_en && (addr == A_BEN)),
        .ctrl_wdata (wr_data[2:0]),
        .ben_wdata  (wr_data[NUM_GRP-1:0]),
        .ctrl       (ctrl),
        .blk_en     (blk_en)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign hit_sts[g] = (addr == ADDR_W'(SRC_BASE + 2*g));
        assign hit_en[g]  = (addr == ADDR_W'(SRC_BASE + 2*g + 1));

        irq_src_grp #(.SRC_W(SRC_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt[g*SRC_W +: SRC_W]),
            .wr_sts    (wr_en && hit_sts[g]),
            .wr_en_reg (wr_en && hit_en[g]),
            .rd_sts    (rd_en && hit_sts[g]),
            .wc_mode   (ctrl.wc_mode),
            .autoclr   (ctrl.autoclr),
            .wr_zero   (wr_zero),
            .wdata     (wr_data[SRC_W-1:0]),
            .sts       (sts_a[g]),
            .en        (en_a[g]),
            .flag      (blk_stat[g])
        );
    end

    // Read-back multiplexer; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        if (addr == A_CTRL)  rd_data = DATA_W'(ctrl);
        if (addr == A_BEN)   rd_data = DATA_W'(blk_en);
        if (addr == A_BSTAT) rd_data = DATA_W'(blk_stat);
        for (int g = 0; g < NUM_GRP; g++) begin
            if (hit_sts[g]) rd_data = DATA_W'(sts_a[g]);
            if (hit_en[g])  rd_data = DATA_W'(en_a[g]);
        end
    end

    // Active-low request: master AND any enabled block with an enabled source bit.
    always_comb int_n = !(ctrl.master && (|(blk_en & blk_stat)));

    // R4
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.master |-> int_n);
    // R4
    block_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en == '0) |-> int_n);
endmodule

// File: tb/irq_hier_ctrl_test.sv
`timescale 1ns/1ps
module irq_hier_ctrl_test;
    localparam int NG = 2;
    localparam int SW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] evt = '0;
    logic        int_n;
    int checks = 0;
    int fails  = 0;

    irq_hier_ctrl #(.NUM_GRP(NG), .SRC_W(SW), .DATA_W(8), .ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .evt(evt), .int_n(int_n)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 4'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 4'(a); rd_en = 1'b1;
        #1 d = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_n", int'(int_n), 1);
        rd(0, v); check("R1 ctrl", v, 0);
        rd(4, v); check("R1 sts0", v, 0);
        rd(7, v); check("R1 en1", v, 0);

        // R2 unused control bits read zero
        wr(0, 8'hFF); rd(0, v); check("R2 ctrl readback", v, 8'h07);
        wr(0, 0);

        // R4 R5 R7 sweep in write-zero mode over every bit and enable combination
        for (int g = 0; g < NG; g++) begin
            for (int i = 0; i < SW; i++) begin
                for (int k = 0; k < 8; k++) begin
                    int m = k & 1;
                    int be = (k >> 1) & 1;
                    int se = (k >> 2) & 1;
                    wr(0, 4 | m);
                    wr(1, be << g);
                    wr(5 + 2*g, se << i);
                    pulse(16'(1) << (g*SW + i));
                    check("R4 gate", int'(int_n), (m & be & se) ? 0 : 1);
                    rd(2, v); check("R5 block status", v, se ? (1 << g) : 0);
                    rd(4 + 2*g, v); check("R7 sts kept after read", v, 1 << i);
                    wr(4 + 2*g, 0);
                    wr(5 + 2*g, 0);
                end
            end
        end

        // R5 block status is read-only
        wr(0, 1); wr(1, 3); wr(5, 8'hFF); pulse(16'h0001);
        wr(2, 8'hFF); rd(2, v); check("R5 write ignored", v, 1);
        rd(4, v);

        // R6 clear-on-read with two active groups
        wr(7, 8'hFF);
        pulse(16'h2008);
        check("R6 int_n asserted", int'(int_n), 0);
        rd(4, v); check("R6 sts0 read", v, 8'h08);
        check("R6 int_n still low", int'(int_n), 0);
        rd(4, v); check("R6 sts0 cleared", v, 0);
        rd(6, v); check("R6 sts1 read", v, 8'h20);
        check("R6 int_n released", int'(int_n), 1);

        // R3 event in the same cycle as a clearing read wins
        @(negedge clk);
        addr = 4'd4; rd_en = 1'b1; evt = 16'h0002;
        #1 v = int'(rd_data);
        check("R3 read before event", v, 0);
        @(negedge clk);
        rd_en = 1'b0; evt = '0;
        rd(4, v); check("R3 event kept", v, 8'h02);

        // R7 R8 write-zero mode
        wr(0, 5);
        pulse(16'h0001);
        rd(4, v); check("R7 first read", v, 1);
        rd(4, v); check("R7 second read", v, 1);
        check("R7 int_n held", int'(int_n), 0);
        wr(4, 8'hFE); rd(4, v); check("R8 nonzero write ignored", v, 1);
        check("R8 int_n held", int'(int_n), 0);
        wr(4, 0); check("R7 int_n after zero write", int'(int_n), 1);
        rd(4, v); check("R7 cleared", v, 0);

        // R9 auto-clear of enables
        wr(0, 7); wr(5, 8'hFF);
        pulse(16'h0014);
        check("R9 int_n before read", int'(int_n), 0);
        rd(4, v); check("R9 status", v, 8'h14);
        rd(5, v); check("R9 enables cleared", v, 8'hEB);
        check("R9 int_n after read", int'(int_n), 1);
        pulse(16'h0004);
        check("R9 repeat event masked", int'(int_n), 1);
        wr(0, 5); wr(5, 8'hFF);
        rd(4, v);
        rd(5, v); check("R9 enables kept", v, 8'hFF);
        check("R9 int_n without autoclear", int'(int_n), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule